// File: doc/BRIEF.md
# Companded-to-Linear PCM Sample Converter

This block converts single audio samples between 8-bit companded codes (µ-law or A-law) and 16-bit two's complement linear words. It sits behind a small write port. One register holds the law selection. A second register takes a companded code, and a third takes a linear word. The expanded linear word and the compressed code appear on two separate outputs. Each output is driven by combinational logic from the stored inputs, so a result is valid in the cycle after the write. No sample clock paces the block, and software may convert at any rate.

The linear word is left-aligned in 16 bits. The law decides how many bits are significant: µ-law uses the upper 14 bits and A-law uses the upper 13. The bits below those are ignored on input and are always zero on output. The block never converts directly from one law to the other. To do that, expand with one law and then compress with the other.

Top module: `pcm_log_lin_conv`

## Requirements
- R1: After reset the law is µ-law (`lawMode` = 0), `linOut` is 0x0000 and `logOut` is 0xFF.
- R2: A write to address 0 sets the law from `wrData[0]` (0 = µ-law, 1 = A-law) on the next clock edge. All other data bits of that write have no effect.
- R3: A write to address 1 stores `wrData[7:0]` as the code to expand. A write to address 2 stores `wrData` as the word to compress. Both results are valid from the cycle after the write, and they hold until the next write.
- R4: In µ-law mode, `linOut` is the G.711 µ-law expansion of the stored code, scaled to 16 bits, with bits [1:0] zero. For example, 0x80 gives 0x7D7C, 0x00 gives 0x8284, 0xEF gives 0x0084, and both 0xFF and 0x7F give 0x0000.
- R5: In A-law mode, `linOut` is the G.711 A-law expansion of the stored code, scaled to 16 bits, with bits [2:0] zero. For example, 0xD5 gives 0x0008, 0x55 gives 0xFFF8, 0xAA gives 0x7E00 and 0x2A gives 0x8200.
- R6: In µ-law mode, `logOut` is the G.711 µ-law code of the stored word's bits [15:2], and bits [1:0] are ignored. For example, 0x0000 and 0x0003 give 0xFF, 0x0004 and 0x0007 give 0xFE, and 0xFFFF gives 0x7E.
- R7: In A-law mode, `logOut` is the G.711 A-law code of the stored word's bits [15:3], and bits [2:0] are ignored. For example, 0x0000 and 0x0007 give 0xD5, 0x0010 and 0x0017 give 0xD4, and 0xFFFF gives 0x55.
- R8: In µ-law mode, a 14-bit magnitude above 8158 saturates to the extreme code of its sign: 0x80 for positive and 0x00 for negative. In A-law mode the extremes are 0xAA and 0x2A.
- R9: For each law and each of the 256 codes, compressing the expanded word returns the original code. The one exception is µ-law code 0x7F (negative zero), which returns 0xFF.
- R10: A change of law recomputes both outputs from the stored inputs, without any new write to the input registers.
- R11: A write to address 3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Register select: 0 law, 1 code in, 2 linear in, 3 unused |
| wrData | input | 16 | Write data |
| lawMode | output | 1 | Current law, 0 µ-law, 1 A-law |
| linOut | output | 16 | Left-aligned linear expansion of the stored code |
| logOut | output | 8 | Companded code of the stored linear word |

## Verification
The hardest situations to reach are the edges of the µ-law magnitude range and the µ-law negative-zero code. Clipping occurs only above a magnitude of 8158, and negative zero is the only code that does not survive a round trip. The stimulus reaches both in two ways. Directed writes put linear words on and just past the clip point, including the most negative word, whose magnitude does not fit the 14-bit field. A full sweep then expands every code under each law and feeds the result straight back in for compression, so the single failing µ-law code is found by the sweep rather than assumed.

// File: rtl/pcm_conv_pkg.sv
package pcm_conv_pkg;
  localparam int LIN_W   = 16;
  localparam int LOG_W   = 8;
  localparam int MU_BITS = 14;
  localparam int A_BITS  = 13;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_LAW   = 2'd0,
    REG_CODE  = 2'd1,
    REG_LIN   = 2'd2,
    REG_SPARE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadCode;
    logic loadLin;
    logic lawA;
  } convStrobe_t;
endpackage

// File: rtl/pcm_conv_ctrl.sv
module pcm_conv_ctrl
  import pcm_conv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              lawBit,
  output convStrobe_t       strobe
);
  regSel_e sel;
  logic    lawReg;

  assign sel = regSel_e'(wrAddr);

  always_ff @(posedge clk) begin
    if (!rstN)                         lawReg <= 1'b0;
    else if (wrEn && sel == REG_LAW)   lawReg <= lawBit;
  end

  always_comb begin
    strobe.loadCode = wrEn && (sel == REG_CODE);
    strobe.loadLin  = wrEn && (sel == REG_LIN);
    strobe.lawA     = lawReg;
  end

  // R3: only one input register is loaded per write
  p_one_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCode, strobe.loadLin}));

  // R2: law follows bit 0 of a write to the law register
  p_law_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0) |=> (strobe.lawA == $past(lawBit)));

  // R11: a write to the spare address leaves the law alone
  p_spare_law_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3) |=> $stable(strobe.lawA));
endmodule

// File: rtl/pcm_expander.sv
module pcm_expander
  import pcm_conv_pkg::*;
(
  input  logic             lawA,
  input  logic [LOG_W-1:0] code,
  output logic [LIN_W-1:0] lin
);
  logic [LOG_W-1:0] muInv, aFlip;
  logic [LIN_W-1:0] muBase, muMag, muLin;
  logic [LIN_W-1:0] aBase, aMag, aLin;

  always_comb begin
    muInv  = ~code;
    muBase = LIN_W'({muInv[3:0], 3'b000}) + 16'd132;
    muMag  = (muBase << muInv[6:4]) - 16'd132;
    muLin  = muInv[7] ? (16'd0 - muMag) : muMag;

    aFlip  = code ^ 8'h55;
    aBase  = LIN_W'({aFlip[3:0], 4'b0000}) +
             ((aFlip[6:4] == 3'd0) ? 16'd8 : 16'd264);
    aMag   = (aFlip[6:4] <= 3'd1) ? aBase : (aBase << (aFlip[6:4] - 3'd1));
    aLin   = aFlip[7] ? aMag : (16'd0 - aMag);

    lin    = lawA ? aLin : muLin;
  end
endmodule

// File: rtl/pcm_compressor.sv
module pcm_compressor
  import pcm_conv_pkg::*;
(
  input  logic               lawA,
  input  logic [MU_BITS-1:0] linTop,
  output logic [LOG_W-1:0]   code
);
  localparam logic [14:0] MU_CLIP = 15'd8158;
  localparam logic [14:0] MU_BIAS = 15'd33;

  logic [14:0] muMag;
  logic [12:0] muBiased;
  logic [2:0]  muSeg;
  logic [3:0]  muMant;
  logic [11:0] aMag;
  logic [2:0]  aSeg;
  logic [3:0]  aMant;
  logic        neg;

  assign neg = linTop[MU_BITS-1];

  always_comb begin
    muMag = neg ? (15'd0 - {1'b1, linTop}) : {1'b0, linTop};
    if (muMag > MU_CLIP) muMag = MU_CLIP;
    muBiased = 13'(muMag + MU_BIAS);
    muSeg = 3'd0;
    for (int i = 0; i < 8; i++)
      if (muBiased[i+5]) muSeg = 3'(i);
    muMant = 4'(muBiased >> ({1'b0, muSeg} + 4'd1));
  end

  always_comb begin
    aMag = neg ? ~linTop[12:1] : linTop[12:1];
    aSeg = 3'd0;
    for (int i = 1; i < 8; i++)
      if (aMag[i+4]) aSeg = 3'(i);
    aMant = 4'(aMag >> ((aSeg == 3'd0) ? 3'd1 : aSeg));
  end

  assign code = lawA ? ({~neg, aSeg, aMant} ^ 8'h55) : ~{neg, muSeg, muMant};
endmodule

// File: rtl/pcm_conv_datapath.sv
module pcm_conv_datapath
  import pcm_conv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  convStrobe_t      strobe,
  input  logic [LIN_W-1:0] wrData,
  output logic [LIN_W-1:0] linOut,
  output logic [LOG_W-1:0] logOut
);
  logic [LOG_W-1:0] codeReg;
  logic [LIN_W-1:0] linReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg <= 8'hFF;
      linReg  <= '0;
    end else begin
      if (strobe.loadCode) codeReg <= wrData[LOG_W-1:0];
      if (strobe.loadLin)  linReg  <= wrData;
    end
  end

  pcm_expander uExp (
    .lawA (strobe.lawA),
    .code (codeReg),
    .lin  (linOut)
  );

  pcm_compressor uCmp (
    .lawA   (strobe.lawA),
    .linTop (linReg[LIN_W-1 -: MU_BITS]),
    .code   (logOut)
  );

  // R3: a code write lands in the register one edge later
  p_code_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCode |=> (codeReg == $past(wrData[LOG_W-1:0])));

  // R11: with no load strobe the inputs hold
  p_lin_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadLin |=> $stable(linReg));

  // R4: µ-law expansion leaves the two bottom bits clear
  p_mu_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lawA |-> (linOut[1:0] == 2'b00));

  // R5: A-law expansion leaves the three bottom bits clear
  p_a_align_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lawA |-> (linOut[2:0] == 3'b000));

  // R8: a large positive µ-law input gives the top positive code
  p_mu_saturate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.lawA && !linReg[15] && linReg[14:2] > 13'd8158) |-> (logOut == 8'h80));
endmodule

// File: rtl/pcm_log_lin_conv.sv
module pcm_log_lin_conv
  import pcm_conv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [15:0] wrData,
  output logic        lawMode,
  output logic [15:0] linOut,
  output logic [7:0]  logOut
);
  convStrobe_t strobe;

  pcm_conv_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .lawBit (wrData[0]),
    .strobe (strobe)
  );

  pcm_conv_datapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .linOut (linOut),
    .logOut (logOut)
  );

  assign lawMode = strobe.lawA;
endmodule

// File: tb/tb_pcm_log_lin_conv.sv
`timescale 1ns/1ps
module tb_pcm_log_lin_conv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        lawMode;
  logic [15:0] linOut;
  logic [7:0]  logOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcm_log_lin_conv dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .lawMode(lawMode), .linOut(linOut), .logOut(logOut)
  );

  // {expand, law, linear word, code}
  localparam int NV = 24;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0000, 8'hFF}, {1'b0, 1'b0, 16'h0003, 8'hFF},
    {1'b0, 1'b0, 16'h0004, 8'hFE}, {1'b0, 1'b0, 16'h0007, 8'hFE},
    {1'b0, 1'b0, 16'hFFFF, 8'h7E}, {1'b0, 1'b0, 16'h7FFF, 8'h80},
    {1'b0, 1'b0, 16'h8000, 8'h00}, {1'b0, 1'b1, 16'h0000, 8'hD5},
    {1'b0, 1'b1, 16'h0007, 8'hD5}, {1'b0, 1'b1, 16'h0010, 8'hD4},
    {1'b0, 1'b1, 16'h0017, 8'hD4}, {1'b0, 1'b1, 16'hFFFF, 8'h55},
    {1'b0, 1'b1, 16'h7FFF, 8'hAA}, {1'b0, 1'b1, 16'h8000, 8'h2A},
    {1'b1, 1'b0, 16'h0000, 8'hFF}, {1'b1, 1'b0, 16'h7D7C, 8'h80},
    {1'b1, 1'b0, 16'h8284, 8'h00}, {1'b1, 1'b0, 16'h0000, 8'h7F},
    {1'b1, 1'b0, 16'h0084, 8'hEF}, {1'b1, 1'b1, 16'h0008, 8'hD5},
    {1'b1, 1'b1, 16'h7E00, 8'hAA}, {1'b1, 1'b1, 16'h8200, 8'h2A},
    {1'b1, 1'b1, 16'hFFF8, 8'h55}, {1'b1, 1'b1, 16'h1580, 8'h80}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] addr, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Independent expansion model, integer arithmetic
  function automatic logic [15:0] refExpand(input bit law, input logic [7:0] c);
    int seg, mant, mag;
    bit pos;
    if (!law) begin
      seg = int'((~c >> 4) & 8'h07); mant = int'(~c & 8'h0F); pos = c[7];
      mag = (mant * 8 + 132) * (2 ** seg) - 132;
    end else begin
      seg = int'(((c ^ 8'h55) >> 4) & 8'h07); mant = int'((c ^ 8'h55) & 8'h0F);
      pos = c[7] ^ 1'b0;
      if (seg == 0) mag = mant * 16 + 8;
      else mag = (mant * 16 + 264) * (2 ** (seg - 1));
    end
    return pos ? 16'(mag) : 16'(-mag);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1 law", {15'd0, lawMode}, 16'd0);
    check("R1 linOut", linOut, 16'h0000);
    check("R1 logOut", {8'd0, logOut}, 16'h00FF);

    // Vector table: R4 R5 expansion, R6 R7 R8 compression
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      writeReg(2'd0, {15'd0, v[24]});
      if (v[25]) begin
        writeReg(2'd1, {8'd0, v[7:0]});
        check(v[24] ? "R5 expand" : "R4 expand", linOut, v[23:8]);
      end else begin
        writeReg(2'd2, v[23:8]);
        check(v[24] ? "R7 compress" : "R6 compress", {8'd0, logOut}, {8'd0, v[7:0]});
      end
    end

    // R8: clip boundary in µ-law
    writeReg(2'd0, 16'h0000);
    writeReg(2'd2, 16'h7F78);
    check("R8 at clip", {8'd0, logOut}, 16'h0080);
    writeReg(2'd2, 16'h7F80);
    check("R8 past clip", {8'd0, logOut}, 16'h0080);
    writeReg(2'd2, 16'h8004);
    check("R8 negative", {8'd0, logOut}, 16'h0000);

    // R2: only bit 0 of the law write counts
    writeReg(2'd0, 16'hFFFE);
    check("R2 bit0 clear", {15'd0, lawMode}, 16'd0);
    writeReg(2'd0, 16'h0001);
    check("R2 bit0 set", {15'd0, lawMode}, 16'd1);

    // R10: law change without new input writes
    writeReg(2'd0, 16'h0000);
    writeReg(2'd1, 16'h0080);
    writeReg(2'd2, 16'h7FFF);
    check("R10 mu lin", linOut, 16'h7D7C);
    check("R10 mu log", {8'd0, logOut}, 16'h0080);
    writeReg(2'd0, 16'h0001);
    check("R10 A lin", linOut, 16'h1580);
    check("R10 A log", {8'd0, logOut}, 16'h00AA);

    // R11: spare address ignored
    writeReg(2'd3, 16'hFFFE);
    check("R11 law", {15'd0, lawMode}, 16'd1);
    check("R11 lin", linOut, 16'h1580);
    check("R11 log", {8'd0, logOut}, 16'h00AA);

    // R3: result holds over idle cycles
    repeat (5) @(negedge clk);
    check("R3 hold", linOut, 16'h1580);

    // R9: full round trip for both laws, with R4 R5 reference values
    for (int law = 0; law < 2; law++) begin
      writeReg(2'd0, 16'(law));
      for (int c = 0; c < 256; c++) begin
        logic [15:0] expanded;
        logic [7:0]  want;
        writeReg(2'd1, 16'(c));
        expanded = linOut;
        check(law ? "R5 sweep" : "R4 sweep", expanded, refExpand(law[0], 8'(c)));
        writeReg(2'd2, expanded);
        want = (law == 0 && c == 8'h7F) ? 8'hFF : 8'(c);
        check("R9 round trip", {8'd0, logOut}, {8'd0, want});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule